// File: doc/BRIEF.md
# ARINC 429 Receive Channel

This block takes one ARINC 429 serial input and turns it into 32-bit words that a host can read. The analog front end has already reduced the line to two digital comparator outputs. One is high while the line is at the positive "one" level. The other is high while it is at the negative "zero" level. When both are low, the line is null. The channel samples these two inputs with a clock enable that runs at ten times the chosen bit rate. It measures each return-to-zero pulse and the null that follows it. It shifts the recovered bits into a word, and it accepts the word only when exactly 32 bits are followed by a long null gap. Accepted words go into a small word FIFO.

The host reads a word through a shared 16-bit tri-state bus. A select input picks the low or the high half. An active-low enable drives the chosen half onto the bus. Reading the high half and then releasing the enable removes the word from the FIFO. Three active-low flags tell the host when data is waiting, when the FIFO is half full and when it is full. A speed input chooses high or low bit rate. A second input switches pulse-timing discrimination off, which lets the channel accept words with loose timing.

Top module: `a429_rx_channel`

## Requirements
- R1: A sample with `line_one`=1 and `line_zero`=0 is a ONE level (bit value 1). A sample with `line_one`=0 and `line_zero`=1 is a ZERO level (bit value 0). A sample with both inputs low is NULL. The first bit received lands in bit 0 of the stored word, and the 32nd bit lands in bit 31.
- R2: The sample enable fires once every `DIV_HI` clocks when `speed_hi`=1 and once every `DIV_LO` clocks when `speed_hi`=0. A word sent at the selected rate is accepted. With discrimination on, a word sent at the low rate is rejected while `speed_hi`=1.
- R3: A word is stored when 32 pulses are followed by at least `GAP_SAMPLES` consecutive NULL samples.
- R4: A word with fewer than 32 bits before the gap is discarded. A word with more than 32 bits before the gap is also discarded.
- R5: With `discr_off_n`=1 (discrimination on), a word is discarded if any pulse lasts fewer than 3 or more than 7 samples. It is also discarded if the null between two bits of the same word is longer than 7 samples.
- R6: With `discr_off_n`=0, pulse width and inter-bit null length are not checked. A 32-bit word with 1-sample pulses is stored.
- R7: `ready_n` is low while at least one word is stored and high when the FIFO is empty, including after reset.
- R8: `half_n` is low while the FIFO holds at least `DEPTH/2` words. `full_n` is low while it holds `DEPTH` words. Both are high after reset.
- R9: A word that completes while the FIFO is full is dropped. The words already stored are read back unchanged and in arrival order.
- R10: While `rd_en_n`=0, the bus carries bits 15:0 of the oldest word when `half_sel`=0 and bits 31:16 when `half_sel`=1. While `rd_en_n`=1, the block does not drive the bus.
- R11: When `rd_en_n` returns high after an enabled cycle with `half_sel`=1, the oldest word is removed. A read that only selects the low half removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_one | input | 1 | Comparator output, high at the positive line level |
| line_zero | input | 1 | Comparator output, high at the negative line level |
| speed_hi | input | 1 | 1 selects the high bit rate, 0 the low bit rate |
| discr_off_n | input | 1 | 0 switches pulse-timing discrimination off |
| half_sel | input | 1 | 0 reads word bits 15:0, 1 reads bits 31:16 |
| rd_en_n | input | 1 | Active-low bus drive enable |
| bus_d | inout | 16 | Shared host data bus |
| ready_n | output | 1 | Low while a word is waiting |
| half_n | output | 1 | Low at or above half occupancy |
| full_n | output | 1 | Low when the FIFO is full |

## Verification
The assertions assume the two comparator outputs are never high together. They assume `speed_hi` and `discr_off_n` change only while the line is idle, and that `rd_en_n` stays low for at least two clocks for each half read. They also assume both dividers are at least 2, so two sample enables are never adjacent. The bench holds every line level for a whole number of sample periods and never raises both comparator inputs. It changes modes only after a full gap, and it holds each read half for two clocks before sampling the bus.

// File: rtl/a429rx_pkg.sv
package a429rx_pkg;

  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned HALF_BITS = 16;

  // shortest and longest acceptable pulse, and longest inter-bit null, in samples
  localparam logic [3:0] PW_MIN = 4'd3;
  localparam logic [3:0] PW_MAX = 4'd7;

  typedef enum logic [1:0] {
    LV_NULL = 2'b00,
    LV_ONE  = 2'b01,
    LV_ZERO = 2'b10,
    LV_BAD  = 2'b11
  } lvl_e;

  function automatic lvl_e decode_lvl(input logic one, input logic zero);
    case ({zero, one})
      2'b01:   return LV_ONE;
      2'b10:   return LV_ZERO;
      2'b00:   return LV_NULL;
      default: return LV_BAD;
    endcase
  endfunction

  function automatic logic pulse_ok(input logic [3:0] n);
    return (n >= PW_MIN) && (n <= PW_MAX);
  endfunction

  function automatic logic space_ok(input logic [7:0] n);
    return n <= 8'(PW_MAX);
  endfunction

  function automatic logic is_pulse(input lvl_e l);
    return (l == LV_ONE) || (l == LV_ZERO);
  endfunction

endpackage

// File: rtl/a429rx_tick.sv
module a429rx_tick #(
  parameter int unsigned DIV_HI = 4,
  parameter int unsigned DIV_LO = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_hi,
  output logic tick
);
  localparam int unsigned DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int unsigned CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = speed_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

endmodule

// File: rtl/a429rx_deframe.sv
module a429rx_deframe
  import a429rx_pkg::*;
#(
  parameter int unsigned GAP_SAMPLES = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_one,
  input  logic                 line_zero,
  input  logic                 discr_en,
  output logic                 word_vld,
  output logic [WORD_BITS-1:0] word_data
);
  localparam logic [7:0] GAP   = 8'(GAP_SAMPLES);
  localparam logic [5:0] NBITS = 6'(WORD_BITS);

  logic [1:0] one_sync, zero_sync;
  lvl_e       cur_lv, prev_lv;
  logic [3:0] pulse_cnt;
  logic [7:0] null_cnt;
  logic [5:0] bit_cnt;
  logic [WORD_BITS-1:0] shreg;
  logic       bad;

  // named events used by the logic and the assertions
  logic cur_null, prev_pulse;
  logic bit_end, pulse_start, flip, gap_hit;
  logic width_good, space_good, bit_take, word_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      one_sync  <= '0;
      zero_sync <= '0;
    end else begin
      one_sync  <= {one_sync[0], line_one};
      zero_sync <= {zero_sync[0], line_zero};
    end
  end

  assign cur_lv      = decode_lvl(one_sync[1], zero_sync[1]);
  assign cur_null    = !is_pulse(cur_lv);
  assign prev_pulse  = is_pulse(prev_lv);
  assign bit_end     = tick && cur_null && prev_pulse;
  assign pulse_start = tick && !cur_null && !prev_pulse;
  assign flip        = tick && !cur_null && prev_pulse && (cur_lv != prev_lv);
  assign gap_hit     = tick && cur_null && !prev_pulse && (null_cnt == GAP - 8'd1);
  assign width_good  = !discr_en || pulse_ok(pulse_cnt);
  assign space_good  = !discr_en || (bit_cnt == '0) || space_ok(null_cnt);
  assign bit_take    = bit_end && width_good && (bit_cnt < NBITS);
  assign word_done   = gap_hit && (bit_cnt == NBITS) && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lv   <= LV_NULL;
      pulse_cnt <= '0;
      null_cnt  <= GAP;
      bit_cnt   <= '0;
      shreg     <= '0;
      bad       <= 1'b0;
      word_vld  <= 1'b0;
    end else begin
      word_vld <= word_done;
      if (tick) begin
        prev_lv <= cur_lv;
        if (cur_null) begin
          if (prev_pulse)          null_cnt <= 8'd1;
          else if (null_cnt < GAP) null_cnt <= null_cnt + 8'd1;
          if (bit_take) begin
            shreg   <= {prev_lv == LV_ONE, shreg[WORD_BITS-1:1]};
            bit_cnt <= bit_cnt + 6'd1;
          end else if (bit_end) begin
            bad <= 1'b1;
          end
          if (gap_hit) begin
            bit_cnt <= '0;
            bad     <= 1'b0;
          end else if (cur_lv == LV_BAD) begin
            bad <= 1'b1;
          end
        end else begin
          null_cnt <= '0;
          if (prev_pulse && !flip) begin
            if (pulse_cnt != 4'hF) pulse_cnt <= pulse_cnt + 4'd1;
          end else begin
            pulse_cnt <= 4'd1;
          end
          if (flip) bad <= 1'b1;
          if (pulse_start) begin
            if (null_cnt == GAP)  bad <= 1'b0;
            else if (!space_good) bad <= 1'b1;
          end
        end
      end
    end
  end

  assign word_data = shreg;

  AST_WORD_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (null_cnt == GAP)); // R3
  AST_WORD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (bit_cnt == '0)); // R4
  AST_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> (bit_cnt <= NBITS)); // R4

endmodule

// File: rtl/a429rx_wfifo.sv
module a429rx_wfifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         half,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign half    = (count >= CW'(DEPTH / 2));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full); // R9
  AST_READY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push) |=> !empty); // R7

endmodule

// File: rtl/a429_rx_channel.sv
module a429_rx_channel
  import a429rx_pkg::*;
#(
  parameter int unsigned DIV_HI      = 4,
  parameter int unsigned DIV_LO      = 32,
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned GAP_SAMPLES = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_one,
  input  logic        line_zero,
  input  logic        speed_hi,
  input  logic        discr_off_n,
  input  logic        half_sel,
  input  logic        rd_en_n,
  inout  wire  [15:0] bus_d,
  output logic        ready_n,
  output logic        half_n,
  output logic        full_n
);
  logic                 tick;
  logic                 word_vld;
  logic [WORD_BITS-1:0] word_data, head;
  logic                 empty, half, full;
  logic                 en_q, sel_q, pop;
  logic [HALF_BITS-1:0] rd_half;

  a429rx_tick #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_tick (
    .clk(clk), .rst_n(rst_n), .speed_hi(speed_hi), .tick(tick)
  );

  a429rx_deframe #(.GAP_SAMPLES(GAP_SAMPLES)) u_deframe (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .line_one(line_one), .line_zero(line_zero), .discr_en(discr_off_n),
    .word_vld(word_vld), .word_data(word_data)
  );

  a429rx_wfifo #(.DEPTH(DEPTH), .W(WORD_BITS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(word_vld), .wdata(word_data),
    .pop(pop), .rdata(head), .empty(empty), .half(half), .full(full)
  );

  // the pop fires when the enable is released after a high-half read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      en_q  <= !rd_en_n;
      sel_q <= half_sel && !rd_en_n;
    end
  end

  assign pop     = rd_en_n && en_q && sel_q;
  assign rd_half = half_sel ? head[WORD_BITS-1:HALF_BITS] : head[HALF_BITS-1:0];
  assign bus_d   = rd_en_n ? 16'bz : rd_half;
  assign ready_n = empty;
  assign half_n  = !half;
  assign full_n  = !full;

  AST_POP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> $rose(rd_en_n)); // R11

endmodule

// File: tb/a429_rx_channel_tb.sv
`timescale 1ns/1ps
module a429_rx_channel_tb;
  localparam int DIV_HI = 4;
  localparam int DIV_LO = 32;
  localparam int DEPTH  = 8;

  typedef struct packed {
    logic [31:0] w;
    logic [3:0]  pw;
    logic        nodisc;
    logic        acc;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{32'hA5A50F0F, 4'd5, 1'b0, 1'b1},
    '{32'h00000000, 4'd5, 1'b0, 1'b1},
    '{32'hFFFFFFFF, 4'd5, 1'b0, 1'b1},
    '{32'h12345678, 4'd4, 1'b0, 1'b1},
    '{32'h80000001, 4'd6, 1'b0, 1'b1},
    '{32'hDEADBEEF, 4'd1, 1'b0, 1'b0},
    '{32'hDEADBEEF, 4'd1, 1'b1, 1'b1},
    '{32'h0BADF00D, 4'd2, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_one = 1'b0, line_zero = 1'b0;
  logic speed_hi = 1'b1, discr_off_n = 1'b1;
  logic half_sel = 1'b0, rd_en_n = 1'b1;
  logic tb_drv = 1'b0;
  wire  [15:0] bus_d;
  logic ready_n, half_n, full_n;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  assign bus_d = tb_drv ? 16'h5A5A : 16'bz;

  a429_rx_channel #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .DEPTH(DEPTH), .GAP_SAMPLES(15)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
    .speed_hi(speed_hi), .discr_off_n(discr_off_n), .half_sel(half_sel),
    .rd_en_n(rd_en_n), .bus_d(bus_d), .ready_n(ready_n), .half_n(half_n), .full_n(full_n)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bit cell: pulse for pw samples, then null for the rest of ten samples
  task automatic send_word(input logic [31:0] w, input int pw, input int nbits, input int sp);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 32) ? w[i] : 1'b1;
      line_one  = b;
      line_zero = !b;
      repeat (pw * sp) @(negedge clk);
      line_one  = 1'b0;
      line_zero = 1'b0;
      repeat ((10 - pw) * sp) @(negedge clk);
    end
    repeat (40 * sp) @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] w, input logic both);
    logic [15:0] lo, hi;
    rd_en_n  = 1'b0;
    half_sel = 1'b0;
    repeat (2) @(negedge clk);
    lo = bus_d;
    hi = 16'h0;
    if (both) begin
      half_sel = 1'b1;
      repeat (2) @(negedge clk);
      hi = bus_d;
    end
    rd_en_n  = 1'b1;
    half_sel = 1'b0;
    repeat (3) @(negedge clk);
    tb_drv = 1'b1;
    @(negedge clk);
    chk(bus_d === 16'h5A5A, "R10 bus released", {16'h0, bus_d}, 32'h5A5A);
    tb_drv = 1'b0;
    @(negedge clk);
    w = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_n === 1'b1, "R7 reset ready", {31'h0, ready_n}, 1);
    chk(half_n === 1'b1 && full_n === 1'b1, "R8 reset flags", {30'h0, half_n, full_n}, 3);

    // table walk: R1 R3 R5 R6 R10 R11
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VT[i];
      discr_off_n = !v.nodisc;
      send_word(v.w, int'(v.pw), 32, DIV_HI);
      chk(ready_n === !v.acc, $sformatf("R3/R5/R6 vector %0d accept", i), {31'h0, ready_n}, {31'h0, !v.acc});
      if (v.acc) begin
        read_word(got, 1'b1);
        chk(got === v.w, $sformatf("R1/R10 vector %0d data", i), got, v.w);
        chk(ready_n === 1'b1, "R11 pop after high half", {31'h0, ready_n}, 1);
      end
      discr_off_n = 1'b1;
    end

    // R4 short and long words
    send_word(32'h55AA55AA, 5, 20, DIV_HI);
    chk(ready_n === 1'b1, "R4 short word dropped", {31'h0, ready_n}, 1);
    send_word(32'h55AA55AA, 5, 33, DIV_HI);
    chk(ready_n === 1'b1, "R4 long word dropped", {31'h0, ready_n}, 1);

    // R11 a low-half-only read keeps the word
    send_word(32'hCAFE1234, 5, 32, DIV_HI);
    read_word(got, 1'b0);
    chk(got[15:0] === 16'h1234, "R10 low half", {16'h0, got[15:0]}, 32'h1234);
    chk(ready_n === 1'b0, "R11 low half keeps word", {31'h0, ready_n}, 0);
    read_word(got, 1'b1);
    chk(got === 32'hCAFE1234, "R11 word after partial read", got, 32'hCAFE1234);

    // R8 R9 fill, overflow, drain
    for (int k = 0; k < DEPTH; k++) begin
      send_word(32'h10000000 + k * 32'h01010101, 5, 32, DIV_HI);
      if (k == DEPTH / 2 - 2)
        chk(half_n === 1'b1, "R8 below half", {31'h0, half_n}, 1);
      if (k == DEPTH / 2 - 1) begin
        chk(half_n === 1'b0, "R8 half", {31'h0, half_n}, 0);
        chk(full_n === 1'b1, "R8 not full", {31'h0, full_n}, 1);
      end
    end
    chk(full_n === 1'b0, "R8 full", {31'h0, full_n}, 0);
    send_word(32'hFFFF0000, 5, 32, DIV_HI);
    for (int k = 0; k < DEPTH; k++) begin
      read_word(got, 1'b1);
      chk(got === 32'h10000000 + k * 32'h01010101, "R9 order after drop", got, 32'h10000000 + k * 32'h01010101);
    end
    chk(ready_n === 1'b1, "R9 dropped word absent", {31'h0, ready_n}, 1);

    // R2 low rate
    speed_hi = 1'b0;
    repeat (100) @(negedge clk);
    send_word(32'h3C3C5A5A, 5, 32, DIV_LO);
    chk(ready_n === 1'b0, "R2 low rate accepted", {31'h0, ready_n}, 0);
    read_word(got, 1'b1);
    chk(got === 32'h3C3C5A5A, "R2 low rate data", got, 32'h3C3C5A5A);
    speed_hi = 1'b1;
    repeat (100) @(negedge clk);
    send_word(32'h3C3C5A5A, 5, 32, DIV_LO);
    chk(ready_n === 1'b1, "R2 rate mismatch rejected", {31'h0, ready_n}, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule